// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the serial-side controller of a byte-wide memory that is attached over a four-wire synchronous serial link. It only ever acts as a slave. It watches the chip select, clock, data-in, pause and write-guard pins. The first byte of every selected frame is an instruction. The block carries out that instruction against an external byte array through a simple address, write-data, write-strobe and read-data port. The byte array is combinationally readable.

The block oversamples all serial pins with its own system clock, so the serial clock must be several system clocks per half period. Data-in is taken on rising serial-clock edges. Data-out changes on falling edges. Bytes travel most significant bit first in both directions. A status byte reports three bits: a busy flag for the timed internal write cycle, a write-enable latch, and a protection-enable bit. The protection-enable bit lets the active-low write-guard pin lock the status byte.

Top module: `spi_mem_slave`

## Requirements
- R1: Bits are taken from `si` on rising `sck` edges and shifted out on `so` after falling `sck` edges, most significant bit first. The first byte after `cs_n` falls is the instruction: 0x06 set-enable, 0x04 clear-enable, 0x05 read-status, 0x01 write-status, 0x03 read, 0x02 write.
- R2: While `cs_n` is high, `so_oe` is 0, `si` and `sck` activity change nothing, and `mem_we` stays 0.
- R3: Any other instruction value locks the frame. `so_oe` stays 0, later bytes in the frame are ignored, and nothing is written. The next fall of `cs_n` restarts decoding.
- R4: Instruction 0x06 sets the enable latch and 0x04 clears it. Read-status returns {bit7 protection-enable, bits6:2 zero, bit1 enable latch, bit0 busy}.
- R5: The read instruction takes a 16-bit address, most significant byte first, and uses its low ADDR_W bits. It then streams bytes from incrementing addresses and wraps from 2^ADDR_W-1 to 0.
- R6: The write instruction with the enable latch set sends every complete data byte to the memory port, one strobe per byte, at incrementing addresses. A trailing partial byte is dropped. With the latch clear, nothing is written.
- R7: A write frame that stored at least one byte starts the internal cycle when `cs_n` rises. Busy reads 1 for WCYC_CYCLES clocks, then busy and the enable latch both clear.
- R8: While busy, every instruction except read-status locks the frame as in R3.
- R9: Write-status with the latch set takes bit 7 of its data byte as protection-enable when `cs_n` rises, and it runs the internal cycle.
- R10: With protection-enable 1, a write-status frame is dropped if `wp_n` is low at `cs_n` rise or at any time during the frame. The status is left unchanged and the enable latch stays set.
- R11: With protection-enable 0, `wp_n` has no effect on write-status.
- R12: Once the internal cycle has begun, `wp_n` falling does not undo the status update.
- R13: A pause starts only when `hold_n` is low while `sck` is low, and ends only when `hold_n` is high while `sck` is low. While paused, `so_oe` is 0 and `sck` edges are ignored. The transfer then resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low status write guard |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| mem_addr | output | ADDR_W | Byte array address for read and write |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-clock write strobe |
| mem_rdata | input | 8 | Byte at `mem_addr`, combinational |

## Verification
The bench builds the block with ADDR_W of 10 so that the read stream can be carried across the top of the array and back to address 0 in a few bytes. It uses a WCYC_CYCLES of 400, which is long enough that a read-status frame issued right after a write still sees busy, and that an instruction sent during the cycle hits the lockout. It is also short enough that waiting for the cycle to finish is cheap. Two synchronizer stages are kept, and the serial half period of eight system clocks covers that latency.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   typedef enum logic [3:0] {
      PH_IDLE, PH_OP, PH_ADDR, PH_RD, PH_WR,
      PH_SRRD, PH_SRWR, PH_DONE, PH_LOCK
   } phase_e;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRITE = 8'h02;

   localparam int SB_BUSY = 0;
   localparam int SB_WEL  = 1;
   localparam int SB_WPEN = 7;

   function automatic logic [7:0] pack_status(input logic busy, input logic wel,
                                              input logic wpen);
      logic [7:0] s;
      s          = '0;
      s[SB_BUSY] = busy;
      s[SB_WEL]  = wel;
      s[SB_WPEN] = wpen;
      return s;
   endfunction

   function automatic phase_e decode_op(input logic [7:0] op, input logic busy);
      phase_e p;
      case (op)
         OP_WREN, OP_WRDI:  p = PH_DONE;
         OP_RDSR:           p = PH_SRRD;
         OP_WRSR:           p = PH_SRWR;
         OP_READ, OP_WRITE: p = PH_ADDR;
         default:           p = PH_LOCK;
      endcase
      if (busy && op != OP_RDSR) p = PH_LOCK;
      return p;
   endfunction

endpackage

// File: rtl/spi_mem_pins.sv
module spi_mem_pins #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sck_i,
   input  logic si_i,
   input  logic hold_n_i,
   input  logic wp_n_i,
   output logic sel_o,
   output logic cs_fall_o,
   output logic cs_rise_o,
   output logic sck_rise_o,
   output logic sck_fall_o,
   output logic si_o,
   output logic held_o,
   output logic wp_n_o
);
   localparam int NPIN = 5;
   localparam logic [NPIN-1:0] PIN_RST = 5'b11100;

   initial assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
      else $fatal(1, "SYNC_STAGES out of range");

   logic [NPIN-1:0] raw, s;
   logic cs_q, sck_q, held;
   logic cs_s, hold_s, sck_s;

   assign raw = {cs_n_i, hold_n_i, wp_n_i, sck_i, si_i};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign s = raw;
      end else begin : g_sync
         logic [NPIN-1:0] chain [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= PIN_RST;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign cs_s   = s[4];
   assign hold_s = s[3];
   assign wp_n_o = s[2];
   assign sck_s  = s[1];
   assign si_o   = s[0];
   assign sel_o  = ~cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
         held  <= 1'b0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
         if (cs_s)        held <= 1'b0;
         else if (!sck_s) held <= ~hold_s;
      end
   end

   assign held_o     = held;
   assign cs_fall_o  = cs_q & ~cs_s;
   assign cs_rise_o  = ~cs_q & cs_s;
   assign sck_rise_o = ~cs_s & ~held & sck_s & ~sck_q;
   assign sck_fall_o = ~cs_s & ~held & ~sck_s & sck_q;

   // R13: a pause may only begin or end while the serial clock is low
   assert_hold_entry_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held) |-> !$past(sck_s));
   assert_hold_exit_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(held) && !cs_s) |-> !$past(sck_s));

endmodule

// File: rtl/spi_mem_wcycle.sv
module spi_mem_wcycle #(
   parameter int WCYC_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_wel_i,
   input  logic clr_wel_i,
   input  logic start_i,
   input  logic sr_load_i,
   input  logic sr_wpen_i,
   output logic busy_o,
   output logic wel_o,
   output logic wpen_o
);
   localparam int CW = $clog2(WCYC_CYCLES + 1);

   initial assert (WCYC_CYCLES >= 1) else $fatal(1, "WCYC_CYCLES must be positive");

   logic [CW-1:0] cnt;
   logic busy, wel, wpen, finish;

   assign finish = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         wpen <= 1'b0;
      end else if (start_i) begin
         busy <= 1'b1;
         cnt  <= CW'(WCYC_CYCLES - 1);
         if (sr_load_i) wpen <= sr_wpen_i;
      end else if (busy) begin
         if (finish) busy <= 1'b0;
         else        cnt  <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wel <= 1'b0;
      else if (finish)    wel <= 1'b0;
      else if (set_wel_i) wel <= 1'b1;
      else if (clr_wel_i) wel <= 1'b0;
   end

   assign busy_o = busy;
   assign wel_o  = wel;
   assign wpen_o = wpen;

   assert_cycle_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);
   assert_wel_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !wel_o);
   assert_wpen_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_i && sr_load_i) |=> $stable(wpen_o));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int WCYC_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic              hold_n,
   input  logic              wp_n,
   output logic              so,
   output logic              so_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   input  logic [7:0]        mem_rdata
);
   initial assert (ADDR_W >= 1 && ADDR_W <= 16) else $fatal(1, "ADDR_W out of range");

   logic sel, cs_fall, cs_rise, sck_rise, sck_fall, si_s, held, wp_n_s;
   logic busy, wel, wpen;

   spi_mem_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
      .hold_n_i(hold_n), .wp_n_i(wp_n), .sel_o(sel), .cs_fall_o(cs_fall),
      .cs_rise_o(cs_rise), .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
      .si_o(si_s), .held_o(held), .wp_n_o(wp_n_s)
   );

   phase_e            phase;
   logic [2:0]        bitc;
   logic [6:0]        rx;
   logic [7:0]        addr_msb;
   logic [ADDR_W-1:0] addr;
   logic              addr_first, is_wr, wrote, sr_frame, sr_pend, sr_wpen, wp_kill;
   logic [6:0]        tx;
   logic              so_q, we_q;
   logic [7:0]        wdata_q;
   logic [7:0]        byte_in, status, src;
   logic              byte_done, op_byte, set_wel, clr_wel;
   logic              start_data, start_sr, wp_block;

   assign byte_in   = {rx, si_s};
   assign byte_done = sck_rise && (bitc == 3'd7);
   assign op_byte   = byte_done && (phase == PH_OP) && !busy;
   assign set_wel   = op_byte && (byte_in == OP_WREN);
   assign clr_wel   = op_byte && (byte_in == OP_WRDI);
   assign status    = pack_status(busy, wel, wpen);
   assign src       = (phase == PH_RD) ? mem_rdata : status;

   assign wp_block   = wpen && !wp_n_s;
   assign start_data = cs_rise && (phase == PH_WR) && wrote && wel && !busy;
   assign start_sr   = cs_rise && sr_pend && wel && !wp_kill && !wp_block && !busy;

   spi_mem_wcycle #(.WCYC_CYCLES(WCYC_CYCLES)) u_wcyc (
      .clk(clk), .rst_n(rst_n), .set_wel_i(set_wel), .clr_wel_i(clr_wel),
      .start_i(start_data | start_sr), .sr_load_i(start_sr), .sr_wpen_i(sr_wpen),
      .busy_o(busy), .wel_o(wel), .wpen_o(wpen)
   );

   // frame sequencing and receive path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         bitc       <= '0;
         rx         <= '0;
         addr_msb   <= '0;
         addr       <= '0;
         addr_first <= 1'b1;
         is_wr      <= 1'b0;
         wrote      <= 1'b0;
         sr_frame   <= 1'b0;
         sr_pend    <= 1'b0;
         sr_wpen    <= 1'b0;
         wp_kill    <= 1'b0;
         we_q       <= 1'b0;
         wdata_q    <= '0;
      end else begin
         we_q <= 1'b0;
         if (we_q) addr <= addr + 1'b1;
         if (cs_fall) begin
            phase      <= PH_OP;
            bitc       <= '0;
            addr_first <= 1'b1;
            wrote      <= 1'b0;
            sr_frame   <= 1'b0;
            sr_pend    <= 1'b0;
            wp_kill    <= 1'b0;
         end else if (cs_rise) begin
            phase <= PH_IDLE;
         end else begin
            if (sel && sr_frame && wp_block) wp_kill <= 1'b1;
            if (sck_rise) begin
               rx   <= byte_in[6:0];
               bitc <= bitc + 3'd1;
               if (bitc == 3'd7) begin
                  case (phase)
                     PH_OP: begin
                        phase    <= decode_op(byte_in, busy);
                        is_wr    <= (byte_in == OP_WRITE);
                        sr_frame <= (byte_in == OP_WRSR) && !busy;
                     end
                     PH_ADDR: begin
                        addr_first <= 1'b0;
                        addr_msb   <= byte_in;
                        if (!addr_first) begin
                           addr  <= ADDR_W'({addr_msb, byte_in});
                           phase <= is_wr ? PH_WR : PH_RD;
                        end
                     end
                     PH_WR: begin
                        if (wel) begin
                           we_q    <= 1'b1;
                           wdata_q <= byte_in;
                           wrote   <= 1'b1;
                        end
                     end
                     PH_RD: addr <= addr + 1'b1;
                     PH_SRWR: begin
                        sr_pend <= 1'b1;
                        sr_wpen <= byte_in[SB_WPEN];
                        phase   <= PH_DONE;
                     end
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   // transmit path: load at the first falling edge of each byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx   <= '0;
         so_q <= 1'b0;
      end else if (sck_fall && (phase == PH_RD || phase == PH_SRRD)) begin
         if (bitc == 3'd0) begin
            so_q <= src[7];
            tx   <= src[6:0];
         end else begin
            so_q <= tx[6];
            tx   <= {tx[5:0], 1'b0};
         end
      end
   end

   assign so        = so_q;
   assign so_oe     = sel && !held && (phase == PH_RD || phase == PH_SRRD);
   assign mem_addr  = addr;
   assign mem_we    = we_q;
   assign mem_wdata = wdata_q;

   assert_quiet_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !so_oe);
   assert_lock_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOCK) |-> (!so_oe && !mem_we));
   assert_write_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);
   assert_busy_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_we) |-> 1'b0);

endmodule

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
   localparam int AW   = 10;
   localparam int WC   = 400;
   localparam int SS   = 2;
   localparam int HALF = 8;
   localparam int MSZ  = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, cs_n, sck, si, hold_n, wp_n, so, so_oe, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   logic [7:0] mem [MSZ];

   spi_mem_slave #(.ADDR_W(AW), .WCYC_CYCLES(WC), .SYNC_STAGES(SS)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .wp_n(wp_n), .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] init_val(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) for (int i = 0; i < MSZ; i++) mem[i] <= init_val(i);
      else if (mem_we) mem[mem_addr] <= mem_wdata;
   end
   always_comb mem_rdata = mem[mem_addr];

   int checks = 0;
   int fails  = 0;
   int cs_hi  = 0;
   logic [AW+7:0] expq [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // per-clock model: expected memory strobes and idle output enable
   always @(negedge clk) begin
      if (rst_n) begin
         cs_hi = cs_n ? cs_hi + 1 : 0;
         if (mem_we) begin
            if (expq.size() == 0) chk(0, "R6 unexpected write", int'(mem_addr), -1);
            else begin
               logic [AW+7:0] e;
               e = expq.pop_front();
               chk({mem_addr, mem_wdata} == e, "R6 write strobe", int'({mem_addr, mem_wdata}), int'(e));
            end
         end
         if (cs_hi > SS + 3 && so_oe) chk(0, "R2 so_oe while deselected", 1, 0);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xbyte(input logic [7:0] t, output logic [7:0] r, output bit oe_all, output bit oe_any);
      oe_all = 1; oe_any = 0; r = '0;
      for (int i = 7; i >= 0; i--) begin
         si = t[i];
         tick(HALF);
         r[i] = so;
         oe_all &= so_oe;
         oe_any |= so_oe;
         sck = 1'b1;
         tick(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic fstart();
      cs_n = 1'b0; tick(HALF);
   endtask
   task automatic fstop();
      tick(HALF); cs_n = 1'b1; tick(2 * HALF);
   endtask

   task automatic send(input logic [7:0] t);
      logic [7:0] r; bit a, b;
      xbyte(t, r, a, b);
   endtask

   task automatic op1(input logic [7:0] op);
      fstart(); send(op); fstop();
   endtask

   task automatic rdsr(output logic [7:0] st);
      bit a, b;
      fstart(); send(8'h05); xbyte(8'h00, st, a, b); fstop();
   endtask

   task automatic wrsr(input logic [7:0] v);
      fstart(); send(8'h01); send(v); fstop();
   endtask

   task automatic chk_sr(input logic [7:0] exp, input string req);
      logic [7:0] st;
      rdsr(st);
      chk(st == exp, req, st, exp);
   endtask

   task automatic chk_read(input logic [15:0] a, input int n, input string req);
      logic [7:0] r; bit oa, ob;
      fstart(); send(8'h03); send(a[15:8]); send(a[7:0]);
      for (int k = 0; k < n; k++) begin
         int ea;
         ea = (int'(a) + k) % MSZ;
         xbyte(8'h00, r, oa, ob);
         chk(r == mem[ea], req, r, mem[ea]);
         chk(oa, {req, " so_oe"}, oa, 1);
      end
      fstop();
   endtask

   initial begin
      logic [7:0] r; bit oa, ob;
      rst_n = 0; cs_n = 1; sck = 0; si = 0; hold_n = 1; wp_n = 1;
      tick(5); rst_n = 1; tick(2);
      chk(!so_oe && !mem_we, "R2 reset outputs", {so_oe, mem_we}, 0);
      chk_sr(8'h00, "R4 reset status");

      // R1: instruction decoded MSB first; bit-reversed WREN is not WREN
      op1(8'h60);
      chk_sr(8'h00, "R1 reversed op");
      op1(8'h06);
      chk_sr(8'h02, "R4 set enable R1");
      op1(8'h04);
      chk_sr(8'h00, "R4 clear enable");

      // R2: clocking with chip select high does nothing
      for (int i = 7; i >= 0; i--) begin
         si = 8'h06 >> i; tick(HALF); sck = 1; tick(HALF); sck = 0;
      end
      chk(!so_oe, "R2 so_oe deselected", so_oe, 0);
      chk_sr(8'h00, "R2 deselected clocks ignored");

      // R3: invalid instruction locks the frame
      fstart(); send(8'hFF); xbyte(8'h06, r, oa, ob); fstop();
      chk(!ob, "R3 locked so_oe", ob, 0);
      chk_sr(8'h00, "R3 later byte ignored");

      // R5: address truncation and wrap
      chk_read(16'hFFFE, 3, "R5 read wrap");
      chk_read(16'h0100, 2, "R5 read R1");

      // R6, R7: write with enable, partial tail byte dropped
      op1(8'h06);
      expq.push_back({AW'(16'h10), 8'hA5});
      expq.push_back({AW'(16'h11), 8'h3C});
      fstart(); send(8'h02); send(8'h00); send(8'h10); send(8'hA5); send(8'h3C);
      for (int i = 0; i < 3; i++) begin
         si = 1; tick(HALF); sck = 1; tick(HALF); sck = 0;
      end
      fstop();
      chk_sr(8'h03, "R7 busy after write");
      tick(WC + 100);
      chk_sr(8'h00, "R7 cycle end clears");
      chk(expq.size() == 0, "R6 all bytes written", expq.size(), 0);
      chk_read(16'h0010, 3, "R6 readback");
      chk(mem[18] == init_val(18), "R6 partial dropped", mem[18], init_val(18));

      // R6: no enable latch, no write and no cycle
      fstart(); send(8'h02); send(8'h00); send(8'h20); send(8'h11); fstop();
      chk_sr(8'h00, "R6 no enable no cycle");

      // R8: instruction during busy is locked out
      op1(8'h06);
      expq.push_back({AW'(16'h30), 8'h77});
      fstart(); send(8'h02); send(8'h00); send(8'h30); send(8'h77); fstop();
      fstart(); send(8'h03); send(8'h00); send(8'h30); xbyte(8'h00, r, oa, ob); fstop();
      chk(!ob, "R8 read during busy", ob, 0);
      tick(WC + 100);
      chk_sr(8'h00, "R8 after cycle");
      chk_read(16'h0030, 1, "R8 data kept");

      // R9: status write sets protection enable
      op1(8'h06);
      wrsr(8'h80);
      chk_sr(8'h83, "R9 busy with new status");
      tick(WC + 100);
      chk_sr(8'h80, "R9 status written");

      // R10: guard low blocks status write
      wp_n = 0;
      op1(8'h06);
      wrsr(8'h00);
      chk_sr(8'h82, "R10 blocked at end");
      wp_n = 1;
      fstart(); send(8'h01); wp_n = 0; tick(4); wp_n = 1; send(8'h00); fstop();
      chk_sr(8'h82, "R10 blocked by pulse");

      // R12: guard falls after cycle started
      wrsr(8'h00);
      wp_n = 0;
      chk_sr(8'h03, "R12 cycle unaffected");
      tick(WC + 100);
      chk_sr(8'h00, "R12 status applied");

      // R11: protection disabled, guard ignored
      op1(8'h06);
      wrsr(8'h80);
      tick(WC + 100);
      chk_sr(8'h80, "R11 guard ignored");
      wp_n = 1;
      op1(8'h06);
      wrsr(8'h00);
      tick(WC + 100);
      chk_sr(8'h00, "R11 restore");

      // R13: pause mid byte
      fstart(); send(8'h03); send(8'h00); send(8'h40);
      r = '0;
      for (int i = 7; i >= 4; i--) begin
         tick(HALF); r[i] = so; sck = 1; tick(HALF); sck = 0;
      end
      tick(HALF); hold_n = 0; tick(HALF);
      chk(!so_oe, "R13 paused so_oe", so_oe, 0);
      repeat (3) begin sck = 1; tick(HALF); sck = 0; tick(HALF); end
      sck = 1; tick(HALF); hold_n = 1; tick(HALF);
      chk(!so_oe, "R13 release needs sck low", so_oe, 0);
      sck = 0; tick(HALF);
      chk(so_oe, "R13 resumed", so_oe, 1);
      for (int i = 3; i >= 0; i--) begin
         tick(HALF); r[i] = so; sck = 1; tick(HALF); sck = 0;
      end
      fstop();
      chk(r == init_val(64), "R13 byte intact", r, init_val(64));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule